// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes a stereo PCM stream carried on three wires (a bit clock, a frame clock that marks channel or frame boundaries, and a serial data line) and turns each frame into a pair of parallel samples. All three wires are brought into the system clock domain through a short synchronizer. Every rising edge of the bit clock is then treated as one bit slot, in which the data bit and the frame clock level are sampled together.

A 4-bit configuration field picks one of four framing conventions and one of three word lengths. Data always arrives most significant bit first in two's complement. Each captured word is sign-extended to 24 bits. The output is a valid/ready stream that carries one left/right pair per frame. The serial side cannot be stalled, so back-pressure works by holding: while a pair waits for `out_ready`, `out_valid` stays high and the data stays unchanged. A frame that completes during that wait is discarded. Changing the configuration field abandons any frame that is only half received.

Top module: `serial_pcm_rx`

## Requirements
- R1: After reset `out_valid` is low, and it stays low until a complete frame has been received.
- R2: `cfg[1:0]` selects the framing: 0 = I2S, 1 = left-justified, 2 = right-justified, 3 = DSP. `cfg[3:2]` selects the word length: 0 = 24, 1 = 20, 2 = 16, and the unused code 3 also means 24 bits.
- R3: In I2S framing, a low frame clock marks the left channel. The MSB is taken from the bit slot after the one in which the frame clock level changes.
- R4: In left-justified framing, a high frame clock marks the left channel. The MSB is taken from the same bit slot in which the frame clock level changes.
- R5: In right-justified framing, a high frame clock marks the left channel. A channel's word is the last N bits sampled before the frame clock changes level, so the LSB sits in the final slot of the half-frame.
- R6: In DSP framing, a frame clock that is high for exactly one bit slot starts a frame. The left MSB follows in the next slot, and the right word starts in the slot right after the left LSB.
- R7: Each output word is the N received bits sign-extended to 24 bits. Bit N-1 is copied into bits 23 down to N.
- R8: Exactly one pair is delivered per complete frame. `out_valid` rises on the 4th rising edge of `clk`, counting the first edge that samples the bit clock high in the slot that completes the right word (SYNC_STAGES + 2). In right-justified mode, that slot is the first one after the right half.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and both samples stay stable. A pair that completes in that time is dropped.
- R10: Bit slots outside the N-bit word have no effect on the delivered samples. These are the trailing slots in I2S, left-justified and DSP framing, and the leading slots in right-justified framing.
- R11: A change of `cfg` discards a left word that has been captured but not yet paired, so the next right word produces no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; it must be several times faster than the bit clock |
| rst_n | input | 1 | Asynchronous-assert active-low reset |
| cfg | input | 4 | Framing select in [1:0] and word length select in [3:2] |
| bclk | input | 1 | Serial bit clock; data is sampled on its rising edge |
| lrclk | input | 1 | Frame clock (channel select, or frame pulse in DSP framing) |
| sdata | input | 1 | Serial data, MSB first |
| out_valid | output | 1 | A left/right pair is being offered |
| out_ready | input | 1 | The consumer accepts the pair on this clock edge |
| out_left | output | 24 | Left sample, sign-extended |
| out_right | output | 24 | Right sample, sign-extended |

## Verification
The pair for a frame is due 4 clock edges after the first `clk` edge that sees the bit clock high in the slot that completes the frame. That slot is the last right bit in most modes and the closing frame clock edge in right-justified mode. When the bench drives that slot, it records the expected pair with its due cycle. On every falling clock edge it compares the outputs against that record. It flags a pair that is missing in its due cycle, a pair that is present before that cycle or when none is expected, and any data mismatch while `out_valid` is high. Because the comparison runs every cycle during back-pressure, the same check also confirms that the held data stays stable.

// File: rtl/spr_pkg.sv
package spr_pkg;

  localparam int SW = 24;
  localparam int CW = $clog2(SW + 1);

  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_DSP = 2'd3
  } fmt_e;

  function automatic logic [CW-1:0] len_of(input logic [1:0] code);
    case (code)
      2'd1:    return CW'(20);
      2'd2:    return CW'(16);
      default: return CW'(24);
    endcase
  endfunction

  function automatic logic [SW-1:0] sign_ext(input logic [SW-1:0] w,
                                             input logic [CW-1:0] n);
    logic [SW-1:0] r;
    for (int i = 0; i < SW; i++)
      r[i] = (i < int'(n)) ? w[i] : w[n - 1'b1];
    return r;
  endfunction

endpackage

// File: rtl/spr_sync.sv
module spr_sync #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins,
  output logic [W-1:0] q,
  output logic         rise
);

  logic [W-1:0] st [STAGES];
  logic         msb_prev;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[g] <= '0;
        else        st[g] <= pins;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[g] <= '0;
        else        st[g] <= st[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) msb_prev <= 1'b0;
    else        msb_prev <= st[STAGES-1][W-1];

  assign q    = st[STAGES-1];
  assign rise = st[STAGES-1][W-1] & ~msb_prev;

endmodule

// File: rtl/spr_frame.sv
module spr_frame
  import spr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  fmt_e          fmt,
  input  logic [CW-1:0] len,
  input  logic          rise,
  input  logic          f,
  input  logic          d,
  output logic          cap_v,
  output logic          cap_ch,
  output logic [SW-1:0] cap_word
);

  logic          fprev, active, pend, chan;
  logic [SW-1:0] hist, acc, nxt;
  logic [CW-1:0] cnt;
  logic          tog, pulse, last;
  logic          restart, rs_chan, rs_delay, rj_cap;

  assign nxt   = {acc[SW-2:0], d};
  assign tog   = rise && (f != fprev);
  assign pulse = rise && f && !fprev;
  assign last  = (cnt == len - 1'b1);

  always_comb begin
    restart  = 1'b0;
    rs_chan  = 1'b0;
    rs_delay = 1'b0;
    rj_cap   = 1'b0;
    case (fmt)
      FMT_I2S: begin restart = tog;   rs_chan = f;  rs_delay = 1'b1; end
      FMT_LJ:  begin restart = tog;   rs_chan = ~f; rs_delay = 1'b0; end
      FMT_DSP: begin restart = pulse; rs_chan = 1'b0; rs_delay = 1'b1; end
      default: rj_cap = tog;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fprev    <= 1'b0;
      hist     <= '0;
      acc      <= '0;
      cnt      <= '0;
      active   <= 1'b0;
      pend     <= 1'b0;
      chan     <= 1'b0;
      cap_v    <= 1'b0;
      cap_ch   <= 1'b0;
      cap_word <= '0;
    end else begin
      cap_v <= 1'b0;
      if (rise) begin
        fprev <= f;
        hist  <= {hist[SW-2:0], d};
      end
      if (clr) begin
        active <= 1'b0;
        pend   <= 1'b0;
      end else if (rise) begin
        if (rj_cap) begin
          cap_v    <= 1'b1;
          cap_ch   <= ~fprev;
          cap_word <= sign_ext(hist, len);
        end
        if (restart) begin
          chan   <= rs_chan;
          pend   <= rs_delay;
          active <= ~rs_delay;
          acc    <= SW'(d);
          cnt    <= CW'(1);
        end else if (pend) begin
          pend   <= 1'b0;
          active <= 1'b1;
          acc    <= SW'(d);
          cnt    <= CW'(1);
        end else if (active) begin
          acc <= nxt;
          cnt <= cnt + 1'b1;
          if (last) begin
            cap_v    <= 1'b1;
            cap_ch   <= chan;
            cap_word <= sign_ext(nxt, len);
            if (fmt == FMT_DSP && !chan) begin
              chan <= 1'b1;
              cnt  <= '0;
            end else begin
              active <= 1'b0;
            end
          end
        end
      end
    end
  end

  // R10
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active && !clr |-> cnt < len);

  // R8
  cap_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_v |-> $past(rise));

  // R7
  sext16_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_v && ($past(len) == CW'(16)) |->
      (cap_word[SW-1:15] == '0) || (cap_word[SW-1:15] == '1));

endmodule

// File: rtl/spr_out.sv
module spr_out
  import spr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          cap_v,
  input  logic          cap_ch,
  input  logic [SW-1:0] cap_word,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [SW-1:0] out_left,
  output logic [SW-1:0] out_right
);

  logic [SW-1:0] lhold;
  logic          lflag;
  logic          load;

  assign load = !clr && cap_v && cap_ch && lflag && (!out_valid || out_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lhold     <= '0;
      lflag     <= 1'b0;
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else begin
      if (clr) begin
        lflag <= 1'b0;
      end else if (cap_v) begin
        if (!cap_ch) begin
          lhold <= cap_word;
          lflag <= 1'b1;
        end else begin
          lflag <= 1'b0;
        end
      end
      if (load) begin
        out_valid <= 1'b1;
        out_left  <= lhold;
        out_right <= cap_word;
      end else if (out_valid && out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R9
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);

  // R9
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_left) && $stable(out_right));

endmodule

// File: rtl/serial_pcm_rx.sv
module serial_pcm_rx
  import spr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    cfg,
  input  logic          bclk,
  input  logic          lrclk,
  input  logic          sdata,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [SW-1:0] out_left,
  output logic [SW-1:0] out_right
);

  localparam int PW = 3;

  logic [3:0]    cfg_q;
  logic          clr;
  fmt_e          fmt;
  logic [CW-1:0] len;
  logic [PW-1:0] sq;
  logic          rise;
  logic          cap_v, cap_ch;
  logic [SW-1:0] cap_word;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg;

  assign clr = (cfg != cfg_q);
  assign fmt = fmt_e'(cfg[1:0]);
  assign len = len_of(cfg[3:2]);

  spr_sync #(.STAGES(SYNC_STAGES), .W(PW)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .pins ({bclk, lrclk, sdata}),
    .q    (sq),
    .rise (rise)
  );

  spr_frame u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .fmt     (fmt),
    .len     (len),
    .rise    (rise),
    .f       (sq[1]),
    .d       (sq[0]),
    .cap_v   (cap_v),
    .cap_ch  (cap_ch),
    .cap_word(cap_word)
  );

  spr_out u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .cap_v    (cap_v),
    .cap_ch   (cap_ch),
    .cap_word (cap_word),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .out_left (out_left),
    .out_right(out_right)
  );

endmodule

// File: tb/tb_serial_pcm_rx.sv
`timescale 1ns/1ps
module tb_serial_pcm_rx;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg = 4'd0;
  logic        bclk = 1'b1, lrclk = 1'b1, sdata = 1'b0;
  logic        out_ready = 1'b1;
  logic        out_valid;
  logic [23:0] out_left, out_right;

  serial_pcm_rx dut (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .bclk(bclk), .lrclk(lrclk),
    .sdata(sdata), .out_valid(out_valid), .out_ready(out_ready),
    .out_left(out_left), .out_right(out_right)
  );

  always #2 clk = ~clk;

  typedef struct {
    logic [23:0] l;
    logic [23:0] r;
    int          due;
    string       tag;
  } exp_t;

  exp_t        exp_q[$];
  int          cyc = 0;
  int          checks = 0;
  int          fails = 0;
  bit          finished = 0;
  bit          mark_now = 0;
  logic [23:0] mk_l, mk_r;
  string       mk_tag;

  always @(posedge clk) cyc = cyc + 1;

  function automatic logic [23:0] sx(input logic [23:0] v, input int w);
    logic signed [23:0] t;
    t = $signed(v << (24 - w));
    return 24'(t >>> (24 - w));
  endfunction

  task automatic send_bit(input logic f, input logic d);
    @(posedge clk); #1;
    bclk = 1'b0; lrclk = f; sdata = d;
    repeat (3) @(posedge clk);
    #1;
    bclk = 1'b1;
    if (mark_now) begin
      if (exp_q.size() == 0) exp_q.push_back('{mk_l, mk_r, cyc + 4, mk_tag});
      mark_now = 0;
    end
    repeat (3) @(posedge clk);
  endtask

  task automatic pad(input logic lvl, input int n);
    for (int i = 0; i < n; i++) send_bit(lvl, 1'($urandom));
  endtask

  task automatic arm(input logic [23:0] l, input logic [23:0] r, input int w, input string tag);
    mk_l = sx(l, w); mk_r = sx(r, w); mk_tag = tag; mark_now = 1;
  endtask

  // half: 0 = left, 1 = right; mark on completing slot when half==1
  task automatic send_frame(input int mode, input int w, input logic [23:0] l,
                            input logic [23:0] r, input string tag);
    if (mode == 3) begin
      send_bit(1'b1, 1'($urandom));
      for (int k = 0; k < w; k++) send_bit(1'b0, l[w-1-k]);
      for (int k = 0; k < w; k++) begin
        if (k == w - 1) arm(l, r, w, tag);
        send_bit(1'b0, r[w-1-k]);
      end
      for (int k = 0; k < 63 - 2 * w; k++) send_bit(1'b0, 1'($urandom));
    end else begin
      for (int h = 0; h < 2; h++) begin
        logic [23:0] wd;
        logic        lv;
        wd = (h == 0) ? l : r;
        if (mode == 0) lv = (h == 1);
        else           lv = (h == 0);
        for (int j = 0; j < 32; j++) begin
          logic b;
          b = 1'($urandom);
          if (mode == 0 && j >= 1 && j - 1 < w) b = wd[w-j];
          if (mode == 1 && j < w) b = wd[w-1-j];
          if (mode == 2 && j >= 32 - w) b = wd[31-j];
          if (h == 1 && mode == 0 && j == w) arm(l, r, w, tag);
          if (h == 1 && mode == 1 && j == w - 1) arm(l, r, w, tag);
          send_bit(lv, b);
        end
      end
      if (mode == 2) begin
        arm(l, r, w, tag);
        send_bit(1'b1, 1'($urandom));
      end
    end
  endtask

  function automatic logic pad_level(input int mode);
    return (mode == 0 || mode == 2);
  endfunction

  function automatic string mode_tag(input int mode);
    case (mode)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  // Per-cycle comparison against the reference queue (R8, R9, R10, R7)
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
        checks++;
        if (!out_valid) begin
          fails++;
          $display("FAIL R8 pair late at cycle %0d: actual out_valid=%0b expected=1", cyc, out_valid);
        end
      end
      if (out_valid) begin
        checks++;
        if (exp_q.size() == 0 || exp_q[0].due > cyc) begin
          fails++;
          $display("FAIL R8 unexpected pair at cycle %0d: actual L=%h R=%h expected none",
                   cyc, out_left, out_right);
        end else begin
          if (out_left !== exp_q[0].l || out_right !== exp_q[0].r) begin
            fails++;
            $display("FAIL %s/R7/R10 data: actual L=%h R=%h expected L=%h R=%h",
                     exp_q[0].tag, out_left, out_right, exp_q[0].l, exp_q[0].r);
          end
          if (out_ready) void'(exp_q.pop_front());
        end
      end
    end
  end

  task automatic summary();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog expired: actual=hung expected=finished");
    summary();
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: actual out_valid=%0b expected=0", out_valid);
    end

    // R3 R4 R5 R6 R7 R10: every framing at every length
    for (int m = 0; m < 4; m++) begin
      for (int lc = 0; lc < 3; lc++) begin
        int w;
        w = (lc == 0) ? 24 : (lc == 1) ? 20 : 16;
        repeat (20) @(posedge clk);
        #1 cfg = {2'(lc), 2'(m)};
        pad(pad_level(m), 4);
        send_frame(m, w, 24'($urandom), 24'($urandom), mode_tag(m));
        send_frame(m, w, 24'(1) << (w - 1), (24'(1) << (w - 1)) - 24'(1), mode_tag(m));
      end
    end

    // R2: unused length code means 24 bits
    repeat (20) @(posedge clk);
    #1 cfg = {2'd3, 2'd1};
    pad(1'b0, 4);
    send_frame(1, 24, 24'h812345, 24'h7ABCDE, "R2");

    // R9: hold under back-pressure, second frame dropped
    repeat (20) @(posedge clk);
    #1 cfg = {2'd0, 2'd0};
    pad(1'b1, 4);
    @(posedge clk); #1 out_ready = 1'b0;
    send_frame(0, 24, 24'hC0FFEE, 24'h123456, "R9");
    send_frame(0, 24, 24'h0A0A0A, 24'h505050, "R9");
    repeat (40) @(posedge clk);
    #1 out_ready = 1'b1;
    repeat (20) @(posedge clk);
    send_frame(0, 24, 24'h654321, 24'hFEDCBA, "R9");

    // R11: configuration change abandons a lone left word
    repeat (20) @(posedge clk);
    #1 cfg = {2'd2, 2'd1};
    pad(1'b0, 4);
    for (int j = 0; j < 32; j++) send_bit(1'b1, (j < 16) ? 1'b1 : 1'b0);
    repeat (20) @(posedge clk);
    #1 cfg = {2'd1, 2'd1};
    for (int j = 0; j < 32; j++) send_bit(1'b0, 1'($urandom));
    pad(1'b0, 4);
    send_frame(1, 20, 24'h0FEDC, 24'h81234, "R11");

    repeat (50) @(posedge clk);
    @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R8 pairs outstanding at end: actual=%0d expected=0", exp_q.size());
    end
    summary();
  end

endmodule